// File: doc/BRIEF.md
# Shadowed Nonvolatile Register Controller

This block keeps a small set of power-on default registers whose values live in a nonvolatile store. After a power-on reset it copies every stored value into a volatile register bank, one register per clock, and only then accepts host writes. The live register values are presented on a flat output bus so the surrounding logic can use them directly.

A host write normally goes to both the volatile copy and the store, and the block reports busy for the programmed store write time. While the volatile-only mode input is high, a write updates the volatile copy alone. It finishes in one cycle, causes no wear on the store, and is lost at the next power cycle. This mode suits calibration loops that try many values before committing one.

The controller is a three-state machine. In `S_LOAD` it reads the store by index. It moves to `S_IDLE` when the last index has been copied. From `S_IDLE`, a normal-mode write moves it to `S_PROG`; a volatile-only write leaves it in `S_IDLE`. It returns from `S_PROG` to `S_IDLE` when the store signals that its write is done. A power-on reset from any state returns it to `S_LOAD`.

Top module: `shreg_ctrl`

## Requirements
- R1: While `por_n` is low, `reg_out` reads all zeros and `busy` is high.
- R2: After `por_n` rises, `busy` stays high until all NREG registers are loaded, which takes exactly NREG clock cycles. On the very first power-up, register i holds INIT_BASE + i (default 8'h50 + i).
- R3: A host write presented while `busy` is high is ignored. This covers both the load period and a store write. The write changes neither the volatile copy nor the store.
- R4: With `vol_mode` low, an accepted write places `wr_data` in register `wr_addr` on the next cycle and also commits it to the store.
- R5: With `vol_mode` low, `busy` is high for exactly WR_CYCLES cycles, starting in the cycle after the write is accepted.
- R6: With `vol_mode` high, an accepted write updates register `wr_addr` on the next cycle and `busy` stays low, so a further write is accepted in the next cycle.
- R7: After any power cycle, each register holds the last value written to it with `vol_mode` low. Values written with `vol_mode` high are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Host write strobe, one write per high cycle |
| wr_addr | input | AW | Register index of the write |
| wr_data | input | DW | Write data |
| vol_mode | input | 1 | High: write the volatile copy only |
| busy | output | 1 | High while loading or while a store write is in progress |
| reg_out | output | NREG*DW | Live register values, register i in bits [i*DW +: DW] |

## Verification
The bench targets writes that arrive during the load sequence and during a store write. A design that let such a write through would show the injected value on `reg_out` or restore it after the next power cycle. It measures the busy window cycle by cycle, because an off-by-one timer would release the host early or late. It also checks that `reg_out` is complete after exactly NREG load cycles. Repeated power cycles with mixed-mode random writes confirm that volatile-only writes vanish while normal writes persist. A design that committed both kinds of write to the store, or neither, fails here.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
    typedef enum logic [1:0] {
        S_LOAD = 2'd0,
        S_IDLE = 2'd1,
        S_PROG = 2'd2
    } shreg_state_t;
endpackage

// File: rtl/shreg_nvm.sv
// Behavioural nonvolatile store: contents survive por_n, writes take WR_CYCLES.
module shreg_nvm #(
    parameter int              NREG      = 4,
    parameter int              DW        = 8,
    parameter int              AW        = 2,
    parameter int              WR_CYCLES = 20,
    parameter logic [DW-1:0]   INIT_BASE = 8'h50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic          wr_done
);
    localparam int CW = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;

    logic [DW-1:0] cells [NREG];
    logic [CW-1:0] cnt;
    logic          pending;
    logic [AW-1:0] lat_idx;
    logic [DW-1:0] lat_data;

    initial begin
        for (int i = 0; i < NREG; i++) begin
            cells[i] = INIT_BASE + DW'(i);
        end
    end

    assign wr_done = pending && (cnt == CW'(WR_CYCLES - 1));
    assign rd_data = cells[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            cnt      <= '0;
            lat_idx  <= '0;
            lat_data <= '0;
        end else if (wr_req && !pending) begin
            pending  <= 1'b1;
            cnt      <= '0;
            lat_idx  <= wr_idx;
            lat_data <= wr_data;
        end else if (wr_done) begin
            pending  <= 1'b0;
            cnt      <= '0;
        end else if (pending) begin
            cnt      <= cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_done) begin
            cells[lat_idx] <= lat_data;
        end
    end
endmodule

// File: rtl/shreg_bank.sv
// Volatile register copy with a load port (priority) and a host port.
module shreg_bank #(
    parameter int NREG = 4,
    parameter int DW   = 8,
    parameter int AW   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_we,
    input  logic [AW-1:0]      ld_idx,
    input  logic [DW-1:0]      ld_data,
    input  logic               hs_we,
    input  logic [AW-1:0]      hs_idx,
    input  logic [DW-1:0]      hs_data,
    output logic [NREG*DW-1:0] flat
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (ld_we) begin
            regs[ld_idx] <= ld_data;
        end else if (hs_we) begin
            regs[hs_idx] <= hs_data;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign flat[g*DW +: DW] = regs[g];
    end
endmodule

// File: rtl/shreg_ctrl.sv
module shreg_ctrl #(
    parameter int            NREG      = 4,
    parameter int            DW        = 8,
    parameter int            AW        = $clog2(NREG),
    parameter int            WR_CYCLES = 20,
    parameter logic [DW-1:0] INIT_BASE = 8'h50
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               vol_mode,
    output logic               busy,
    output logic [NREG*DW-1:0] reg_out
);
    import shreg_pkg::*;

    localparam logic [AW-1:0] LAST_IDX = AW'(NREG - 1);

    shreg_state_t st, st_nx;
    logic [AW-1:0] ld_idx;
    logic [DW-1:0] nv_rdata;
    logic          nv_done;
    logic          accept;
    logic          nv_req;
    logic          ld_we;
    logic          load_done;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st <= S_LOAD;
        end else begin
            st <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_LOAD: if (ld_idx == LAST_IDX) st_nx = S_IDLE;
            S_IDLE: if (nv_req)             st_nx = S_PROG;
            S_PROG: if (nv_done)            st_nx = S_IDLE;
            default:                        st_nx = S_LOAD;
        endcase
    end

    // outputs and strobes
    always_comb begin
        busy      = 1'b1;
        accept    = 1'b0;
        ld_we     = 1'b0;
        load_done = 1'b1;
        unique case (st)
            S_LOAD: begin
                ld_we     = 1'b1;
                load_done = 1'b0;
            end
            S_IDLE: begin
                busy   = 1'b0;
                accept = wr_en;
            end
            S_PROG: ;
            default: load_done = 1'b0;
        endcase
    end

    assign nv_req = accept && !vol_mode;

    // load index
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ld_idx <= '0;
        end else if (ld_we) begin
            ld_idx <= ld_idx + AW'(1);
        end
    end

    shreg_nvm #(
        .NREG(NREG), .DW(DW), .AW(AW),
        .WR_CYCLES(WR_CYCLES), .INIT_BASE(INIT_BASE)
    ) u_nvm (
        .clk     (clk),
        .rst_n   (por_n),
        .rd_idx  (ld_idx),
        .rd_data (nv_rdata),
        .wr_req  (nv_req),
        .wr_idx  (wr_addr),
        .wr_data (wr_data),
        .wr_done (nv_done)
    );

    shreg_bank #(
        .NREG(NREG), .DW(DW), .AW(AW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (por_n),
        .ld_we   (ld_we),
        .ld_idx  (ld_idx),
        .ld_data (nv_rdata),
        .hs_we   (accept),
        .hs_idx  (wr_addr),
        .hs_data (wr_data),
        .flat    (reg_out)
    );
endmodule

// File: rtl/shreg_ctrl_chk.sv
module shreg_ctrl_chk #(
    parameter int NREG      = 4,
    parameter int DW        = 8,
    parameter int AW        = 2,
    parameter int WR_CYCLES = 20
) (
    input logic               clk,
    input logic               por_n,
    input logic               wr_en,
    input logic [AW-1:0]      wr_addr,
    input logic [DW-1:0]      wr_data,
    input logic               vol_mode,
    input logic               busy,
    input logic [NREG*DW-1:0] reg_out,
    input logic               load_done
);
    int busy_run;

    function automatic logic [DW-1:0] pick(input logic [NREG*DW-1:0] v, input logic [AW-1:0] i);
        return v[i*DW +: DW];
    endfunction

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            busy_run <= 0;
        end else if (busy && load_done) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (por_n)
        !por_n |=> (busy && reg_out == '0));

    assert_busy_gate_R3: assert property (@(posedge clk) disable iff (!por_n)
        (busy && load_done) |=> $stable(reg_out));

    assert_nv_write_R4: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !vol_mode && !busy) |=> (busy && pick(reg_out, $past(wr_addr)) == $past(wr_data)));

    assert_busy_origin_R5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> $past(wr_en && !vol_mode));

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(busy) && $past(load_done)) |-> (busy_run == WR_CYCLES));

    assert_vol_write_R6: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && vol_mode && !busy) |=> (!busy && pick(reg_out, $past(wr_addr)) == $past(wr_data)));
endmodule

bind shreg_ctrl shreg_ctrl_chk #(
    .NREG(NREG), .DW(DW), .AW(AW), .WR_CYCLES(WR_CYCLES)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .vol_mode  (vol_mode),
    .busy      (busy),
    .reg_out   (reg_out),
    .load_done (load_done)
);

// File: tb/sim_shreg_ctrl.sv
`timescale 1ns/1ps
module sim_shreg_ctrl;
    localparam int            NREG      = 4;
    localparam int            DW        = 8;
    localparam int            AW        = 2;
    localparam int            WR_CYCLES = 20;
    localparam logic [DW-1:0] INIT_BASE = 8'h50;

    logic               clk = 1'b0;
    logic               por_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [AW-1:0]      wr_addr = '0;
    logic [DW-1:0]      wr_data = '0;
    logic               vol_mode = 1'b0;
    logic               busy;
    logic [NREG*DW-1:0] reg_out;

    logic [DW-1:0] exp_vol [NREG];
    logic [DW-1:0] exp_nv  [NREG];
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    shreg_ctrl #(
        .NREG(NREG), .DW(DW), .AW(AW), .WR_CYCLES(WR_CYCLES), .INIT_BASE(INIT_BASE)
    ) u0 (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vol_mode(vol_mode), .busy(busy), .reg_out(reg_out)
    );

    function automatic logic [NREG*DW-1:0] pack_vol();
        logic [NREG*DW-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*DW +: DW] = exp_vol[i];
        return v;
    endfunction

    task automatic chk(input string req, input logic [NREG*DW-1:0] act, input logic [NREG*DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // power cycle; optional write attempts during the load window
    task automatic power_cycle(input bit inject);
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 regs clear", reg_out, '0);
        chk("R1 busy high", {{(NREG*DW-1){1'b0}}, busy}, 1);
        por_n = 1'b1;
        if (inject) begin
            wr_en = 1'b1; vol_mode = 1'b1; wr_addr = '0; wr_data = 8'hEE;
        end
        @(negedge clk);
        chk("R2 busy during load", {{(NREG*DW-1){1'b0}}, busy}, 1);
        repeat (NREG - 1) @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < NREG; i++) exp_vol[i] = exp_nv[i];
        chk("R2 busy low after load", {{(NREG*DW-1){1'b0}}, busy}, 0);
        chk(inject ? "R3 load-time write ignored" : "R7 restored values", reg_out, pack_vol());
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit m);
        int n;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; vol_mode = m;
        @(negedge clk);
        wr_en = 1'b0;
        exp_vol[a] = d;
        if (!m) exp_nv[a] = d;
        if (m) begin
            chk("R6 volatile write", reg_out, pack_vol());
            chk("R6 busy stays low", {{(NREG*DW-1){1'b0}}, busy}, 0);
        end else begin
            chk("R4 normal write", reg_out, pack_vol());
            n = 0;
            while (busy && n < 1000) begin
                n++;
                @(negedge clk);
            end
            chk("R5 busy length", NREG*DW'(n), NREG*DW'(WR_CYCLES));
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_nv[i] = INIT_BASE + DW'(i);
        void'($urandom(32'd91));
        @(negedge clk);
        @(negedge clk);
        chk("R1 regs clear at power-up", reg_out, '0);
        por_n = 1'b1;
        @(negedge clk);
        chk("R2 busy during first load", {{(NREG*DW-1){1'b0}}, busy}, 1);
        repeat (NREG - 1) @(negedge clk);
        for (int i = 0; i < NREG; i++) exp_vol[i] = exp_nv[i];
        chk("R2 initial contents", reg_out, pack_vol());
        chk("R2 busy low", {{(NREG*DW-1){1'b0}}, busy}, 0);

        power_cycle(1'b1);

        do_write(2'd1, 8'h3C, 1'b0);
        do_write(2'd2, 8'h77, 1'b1);
        // back-to-back volatile writes on consecutive cycles
        @(negedge clk);
        wr_en = 1'b1; vol_mode = 1'b1; wr_addr = 2'd3; wr_data = 8'h88;
        @(negedge clk);
        wr_addr = 2'd0; wr_data = 8'h99;
        @(negedge clk);
        wr_en = 1'b0;
        exp_vol[3] = 8'h88; exp_vol[0] = 8'h99;
        chk("R6 back-to-back accepted", reg_out, pack_vol());

        // writes during a store write are ignored
        @(negedge clk);
        wr_en = 1'b1; vol_mode = 1'b0; wr_addr = 2'd0; wr_data = 8'h11;
        @(negedge clk);
        exp_vol[0] = 8'h11; exp_nv[0] = 8'h11;
        wr_addr = 2'd3; wr_data = 8'hAA;
        repeat (3) @(negedge clk);
        vol_mode = 1'b1; wr_addr = 2'd2; wr_data = 8'hBB;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        while (busy) @(negedge clk);
        chk("R3 write during busy ignored", reg_out, pack_vol());

        power_cycle(1'b0);

        for (int k = 0; k < 60; k++) begin
            if (($urandom % 8) == 0) power_cycle(1'b0);
            else do_write(AW'($urandom % NREG), DW'($urandom), 1'($urandom % 2));
        end
        power_cycle(1'b0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule